// File: doc/BRIEF.md
# Host FIFO Port Access Decoder

This block joins a 32-bit host register bus to four FIFOs: transmit data, receive data, transmit status and receive status. Host reads and writes are decoded into push, pop and peek operations. Each data FIFO answers anywhere inside an eight-DWORD window, so a host can burst through rising addresses. Each status FIFO has two read locations: one removes the oldest entry and one only looks at it.

A direct-access input overrides normal decoding. While it is high, every write goes to transmit data and every read comes from receive data. Only address bit 2 is used in this mode, and it marks the DWORD boundaries inside a burst in which the strobe is held. An endian input reverses the bytes of data-FIFO words. Status words always pass unchanged.

The network side of each FIFO is a valid/ready stream. A beat moves on a clock edge where valid and ready are both high. A producer holds valid and data steady until ready is seen, so back-pressure is simply ready held low. The receive-side FIFOs drop ready while full. The transmit data output keeps valid high and its data stable until it is accepted.

Top module: `hfp_host_port`

## Requirements
- R1: A read whose byte address is anywhere from 0x000 to 0x01C pops the receive data FIFO. All eight DWORD aliases behave identically.
- R2: A write whose byte address is anywhere from 0x020 to 0x03C pushes the write data into the transmit data FIFO.
- R3: A read of 0x040 returns and pops the oldest receive status entry. A read of 0x048 does the same for transmit status.
- R4: A read of 0x044 (receive status) or 0x04C (transmit status) returns the oldest entry and leaves the FIFO unchanged.
- R5: While `direct_sel` is high, every write access pushes transmit data and every read access pops receive data, whatever the address.
- R6: In direct mode a held strobe counts as one access on its first cycle and one more access on each cycle where address bit 2 differs from the cycle before. Other address bits are ignored.
- R7: While `big_endian` is high, data-FIFO words are byte-reversed: byte 0 is swapped with byte 3, and byte 1 with byte 2. This applies in both directions. Status reads are never swapped.
- R8: A pop or peek of an empty FIFO returns zero and sets the sticky `underrun` flag. A pulse on `err_clr` clears the flag.
- R9: A host push into a full transmit data FIFO is dropped and sets the sticky `overrun` flag. A pulse on `err_clr` clears the flag.
- R10: `host_rdata` is registered. It is valid one clock after the read access and holds until the next read access. A read held over consecutive cycles returns consecutive entries.
- R11: Each network-side port follows valid/ready. Transmit data `valid` is high while that FIFO is non-empty. Each receive-side `ready` is low while its FIFO is full.
- R12: Writes to addresses outside the transmit data window have no effect. Reads of unmapped locations, including the transmit data window, return zero and pop nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | AW | Host byte address (bits 1:0 unused) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| direct_sel | input | 1 | Direct-access mode select |
| big_endian | input | 1 | Byte reversal for data-FIFO words |
| err_clr | input | 1 | Clears sticky error flags |
| underrun | output | 1 | Sticky: pop or peek of an empty FIFO |
| overrun | output | 1 | Sticky: push into full transmit data FIFO |
| txd_m_valid | output | 1 | Transmit data stream valid |
| txd_m_ready | input | 1 | Transmit data stream ready |
| txd_m_data | output | 32 | Transmit data stream word |
| rxd_s_valid | input | 1 | Receive data stream valid |
| rxd_s_ready | output | 1 | Receive data stream ready |
| rxd_s_data | input | 32 | Receive data stream word |
| rxs_s_valid | input | 1 | Receive status stream valid |
| rxs_s_ready | output | 1 | Receive status stream ready |
| rxs_s_data | input | 32 | Receive status word |
| txs_s_valid | input | 1 | Transmit status stream valid |
| txs_s_ready | output | 1 | Transmit status stream ready |
| txs_s_data | input | 32 | Transmit status word |

## Verification
The bench repeats peeks to show they never advance a status FIFO. A decoder that confused the peek and pop offsets would return the second entry early. It reads through different aliases with the endian input toggled, and checks that status words stay unswapped, which catches a swap applied to the wrong path.

In direct mode it holds the read strobe while toggling bit 2, then changes only upper address bits. A design that counted cycles instead of bit-2 transitions would pop extra entries. A design that decoded the upper bits would miss pops or hit a status FIFO.

It overfills the transmit FIFO to catch a design that overwrites data or loses the overrun flag. It reads an empty status FIFO, where a design that failed to return zero or failed to raise underrun would be exposed.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
  localparam int DW = 32;
  localparam int NB = DW / 8;

  // DWORD indices (byte offset >> 2) of the status locations
  localparam logic [5:0] IDX_RXS_POP  = 6'h10;
  localparam logic [5:0] IDX_RXS_PEEK = 6'h11;
  localparam logic [5:0] IDX_TXS_POP  = 6'h12;
  localparam logic [5:0] IDX_TXS_PEEK = 6'h13;
  // data windows selected by DWORD index bits [5:3]
  localparam logic [2:0] WIN_RXD = 3'd0;
  localparam logic [2:0] WIN_TXD = 3'd1;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_RXD, SRC_RXS_POP, SRC_RXS_PEEK, SRC_TXS_POP, SRC_TXS_PEEK
  } rd_src_e;

  typedef struct packed {
    logic txd_push;
    logic rxd_pop;
    logic rxs_pop;
    logic rxs_peek;
    logic txs_pop;
    logic txs_peek;
  } strobes_t;
endpackage

// File: rtl/hfp_fifo.sv
module hfp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CFULL);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CFULL);
  p_peek_keeps_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !empty) |=> $stable(head));
endmodule

// File: rtl/hfp_byte_order.sv
module hfp_byte_order (
  input  logic                 swap,
  input  logic [hfp_pkg::DW-1:0] din,
  output logic [hfp_pkg::DW-1:0] dout
);
  import hfp_pkg::*;
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign dout[8*b +: 8] = swap ? din[8*(NB-1-b) +: 8] : din[8*b +: 8];
  end
endmodule

// File: rtl/hfp_decode.sv
module hfp_decode #(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [AW-1:0]     host_addr,
  input  logic              direct_sel,
  output hfp_pkg::strobes_t st,
  output logic              rd_acc,
  output hfp_pkg::rd_src_e  src
);
  import hfp_pkg::*;
  localparam int IW = AW - 2;

  logic [IW-1:0] idx;
  logic [5:0]    low6;
  logic          hi_zero, a2, prev_a2, prev_rd, prev_wr, step, wr_acc;

  assign idx     = host_addr[AW-1:2];
  assign low6    = idx[5:0];
  assign hi_zero = ((idx >> 6) == '0);
  assign a2      = host_addr[2];
  assign step    = a2 ^ prev_a2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_a2 <= 1'b0;
      prev_rd <= 1'b0;
      prev_wr <= 1'b0;
    end else begin
      prev_a2 <= a2;
      prev_rd <= host_rd;
      prev_wr <= host_wr;
    end
  end

  assign rd_acc = host_rd && (!direct_sel || !prev_rd || step);
  assign wr_acc = host_wr && (!direct_sel || !prev_wr || step);

  always_comb begin
    st  = '0;
    src = SRC_NONE;
    if (direct_sel) begin
      st.txd_push = wr_acc;
      if (rd_acc) begin
        st.rxd_pop = 1'b1;
        src        = SRC_RXD;
      end
    end else begin
      st.txd_push = wr_acc && hi_zero && (low6[5:3] == WIN_TXD);
      if (rd_acc && hi_zero) begin
        if (low6[5:3] == WIN_RXD) begin
          st.rxd_pop = 1'b1;
          src        = SRC_RXD;
        end else begin
          case (low6)
            IDX_RXS_POP:  begin st.rxs_pop  = 1'b1; src = SRC_RXS_POP;  end
            IDX_RXS_PEEK: begin st.rxs_peek = 1'b1; src = SRC_RXS_PEEK; end
            IDX_TXS_POP:  begin st.txs_pop  = 1'b1; src = SRC_TXS_POP;  end
            IDX_TXS_PEEK: begin st.txs_peek = 1'b1; src = SRC_TXS_PEEK; end
            default:      src = SRC_NONE;
          endcase
        end
      end
    end
  end

  p_one_read_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st.rxd_pop, st.rxs_pop, st.rxs_peek, st.txs_pop, st.txs_peek}));
  p_direct_no_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    direct_sel |-> !(st.rxs_pop || st.rxs_peek || st.txs_pop || st.txs_peek));
  p_burst_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_sel && host_rd && $past(host_rd) && (a2 == $past(a2))) |-> !st.rxd_pop);
endmodule

// File: rtl/hfp_host_port.sv
module hfp_host_port #(
  parameter int AW        = 8,
  parameter int TXD_DEPTH = 8,
  parameter int RXD_DEPTH = 8,
  parameter int STS_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic          direct_sel,
  input  logic          big_endian,
  input  logic          err_clr,
  output logic          underrun,
  output logic          overrun,
  output logic          txd_m_valid,
  input  logic          txd_m_ready,
  output logic [31:0]   txd_m_data,
  input  logic          rxd_s_valid,
  output logic          rxd_s_ready,
  input  logic [31:0]   rxd_s_data,
  input  logic          rxs_s_valid,
  output logic          rxs_s_ready,
  input  logic [31:0]   rxs_s_data,
  input  logic          txs_s_valid,
  output logic          txs_s_ready,
  input  logic [31:0]   txs_s_data
);
  import hfp_pkg::*;

  strobes_t st;
  rd_src_e  src;
  logic     rd_acc;
  logic [DW-1:0] wr_ordered, rxd_head, rxd_ordered, rxs_head, txs_head;
  logic rxd_empty, rxd_full, rxs_empty, rxs_full, txs_empty, txs_full;
  logic txd_empty, txd_full, empty_hit, full_hit;

  hfp_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .direct_sel(direct_sel),
    .st(st), .rd_acc(rd_acc), .src(src)
  );

  hfp_byte_order u_wr_order (.swap(big_endian), .din(host_wdata), .dout(wr_ordered));
  hfp_byte_order u_rd_order (.swap(big_endian), .din(rxd_head),   .dout(rxd_ordered));

  hfp_fifo #(.W(DW), .DEPTH(TXD_DEPTH)) u_txd (
    .clk(clk), .rst_n(rst_n), .push(st.txd_push), .push_data(wr_ordered),
    .pop(txd_m_valid && txd_m_ready), .head(txd_m_data),
    .empty(txd_empty), .full(txd_full)
  );
  assign txd_m_valid = !txd_empty;

  hfp_fifo #(.W(DW), .DEPTH(RXD_DEPTH)) u_rxd (
    .clk(clk), .rst_n(rst_n), .push(rxd_s_valid && rxd_s_ready),
    .push_data(rxd_s_data), .pop(st.rxd_pop), .head(rxd_head),
    .empty(rxd_empty), .full(rxd_full)
  );
  assign rxd_s_ready = !rxd_full;

  hfp_fifo #(.W(DW), .DEPTH(STS_DEPTH)) u_rxs (
    .clk(clk), .rst_n(rst_n), .push(rxs_s_valid && rxs_s_ready),
    .push_data(rxs_s_data), .pop(st.rxs_pop), .head(rxs_head),
    .empty(rxs_empty), .full(rxs_full)
  );
  assign rxs_s_ready = !rxs_full;

  hfp_fifo #(.W(DW), .DEPTH(STS_DEPTH)) u_txs (
    .clk(clk), .rst_n(rst_n), .push(txs_s_valid && txs_s_ready),
    .push_data(txs_s_data), .pop(st.txs_pop), .head(txs_head),
    .empty(txs_empty), .full(txs_full)
  );
  assign txs_s_ready = !txs_full;

  // read data register: holds between read accesses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (rd_acc) begin
      case (src)
        SRC_RXD:      host_rdata <= rxd_empty ? '0 : rxd_ordered;
        SRC_RXS_POP,
        SRC_RXS_PEEK: host_rdata <= rxs_empty ? '0 : rxs_head;
        SRC_TXS_POP,
        SRC_TXS_PEEK: host_rdata <= txs_empty ? '0 : txs_head;
        default:      host_rdata <= '0;
      endcase
    end
  end

  assign empty_hit = (st.rxd_pop && rxd_empty)
                   || ((st.rxs_pop || st.rxs_peek) && rxs_empty)
                   || ((st.txs_pop || st.txs_peek) && txs_empty);
  assign full_hit  = st.txd_push && txd_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      underrun <= 1'b0;
      overrun  <= 1'b0;
    end else if (err_clr) begin
      underrun <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (empty_hit) underrun <= 1'b1;
      if (full_hit)  overrun  <= 1'b1;
    end
  end

  p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !err_clr) |=> underrun);
  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_clr) |=> overrun);
  p_txd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_m_valid && !txd_m_ready) |=> (txd_m_valid && $stable(txd_m_data)));
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));
endmodule

// File: tb/hfp_host_port_test.sv
module hfp_host_port_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic direct_sel = 1'b0, big_endian = 1'b0, err_clr = 1'b0;
  logic underrun, overrun;
  logic txd_m_valid, txd_m_ready = 1'b0;
  logic [31:0] txd_m_data;
  logic rxd_s_valid = 1'b0, rxd_s_ready; logic [31:0] rxd_s_data = '0;
  logic rxs_s_valid = 1'b0, rxs_s_ready; logic [31:0] rxs_s_data = '0;
  logic txs_s_valid = 1'b0, txs_s_ready; logic [31:0] txs_s_data = '0;

  int n_chk = 0, n_bad = 0;

  hfp_host_port #(.AW(8), .TXD_DEPTH(4), .RXD_DEPTH(4), .STS_DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .direct_sel(direct_sel), .big_endian(big_endian), .err_clr(err_clr),
    .underrun(underrun), .overrun(overrun),
    .txd_m_valid(txd_m_valid), .txd_m_ready(txd_m_ready), .txd_m_data(txd_m_data),
    .rxd_s_valid(rxd_s_valid), .rxd_s_ready(rxd_s_ready), .rxd_s_data(rxd_s_data),
    .rxs_s_valid(rxs_s_valid), .rxs_s_ready(rxs_s_ready), .rxs_s_data(rxs_s_data),
    .txs_s_valid(txs_s_valid), .txs_s_ready(txs_s_ready), .txs_s_data(txs_s_data)
  );

  // {chk, rd, wr, be, addr[7:0], wdata[31:0], exp[31:0]}
  localparam int NV = 14;
  localparam logic [75:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,1'b0,8'h44,32'h0,32'hA000_0001},        // R4 rx peek
    {1'b1,1'b1,1'b0,1'b0,8'h44,32'h0,32'hA000_0001},        // R4 peek again
    {1'b1,1'b1,1'b0,1'b0,8'h40,32'h0,32'hA000_0001},        // R3 rx pop
    {1'b1,1'b1,1'b0,1'b0,8'h40,32'h0,32'hA000_0002},        // R3 rx pop
    {1'b1,1'b1,1'b0,1'b0,8'h40,32'h0,32'h0},                // R8 empty
    {1'b1,1'b1,1'b0,1'b1,8'h4C,32'h0,32'hB000_0001},        // R4 R7 tx peek unswapped
    {1'b1,1'b1,1'b0,1'b0,8'h48,32'h0,32'hB000_0001},        // R3 tx pop
    {1'b1,1'b1,1'b0,1'b0,8'h00,32'h0,32'h1122_3344},        // R1 base
    {1'b1,1'b1,1'b0,1'b1,8'h1C,32'h0,32'h8877_6655},        // R1 R7 last alias swapped
    {1'b1,1'b1,1'b0,1'b0,8'h10,32'h0,32'h99AA_BBCC},        // R1 mid alias
    {1'b0,1'b0,1'b1,1'b0,8'h20,32'hDEAD_BEEF,32'h0},        // R2 push
    {1'b0,1'b0,1'b1,1'b1,8'h3C,32'h0102_0304,32'h0},        // R2 R7 push swapped
    {1'b0,1'b0,1'b1,1'b0,8'h44,32'h1234_5678,32'h0},        // R12 ignored write
    {1'b1,1'b1,1'b0,1'b0,8'h20,32'h0,32'h0}                 // R12 unreadable
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic host_op(input logic rd, input logic wr, input logic be,
                         input logic [7:0] a, input logic [31:0] wd,
                         output logic [31:0] rv);
    @(negedge clk);
    host_rd = rd; host_wr = wr; big_endian = be; host_addr = a; host_wdata = wd;
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0; big_endian = 1'b0;
    rv = host_rdata;
  endtask

  // which: 0 rx data, 1 rx status, 2 tx status
  task automatic mac_push(input int which, input logic [31:0] d);
    @(negedge clk);
    case (which)
      0: begin rxd_s_valid = 1'b1; rxd_s_data = d; end
      1: begin rxs_s_valid = 1'b1; rxs_s_data = d; end
      default: begin txs_s_valid = 1'b1; txs_s_data = d; end
    endcase
    @(negedge clk);
    rxd_s_valid = 1'b0; rxs_s_valid = 1'b0; txs_s_valid = 1'b0;
  endtask

  task automatic mac_take(output logic v, output logic [31:0] d);
    @(negedge clk);
    v = txd_m_valid; d = txd_m_data; txd_m_ready = 1'b1;
    @(negedge clk);
    txd_m_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] rv, d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R10 reset rdata", host_rdata, 32'h0);
    check("R8 reset underrun", {31'b0, underrun}, 32'h0);
    check("R11 reset txd valid", {31'b0, txd_m_valid}, 32'h0);
    check("R11 reset rxd ready", {31'b0, rxd_s_ready}, 32'h1);

    mac_push(0, 32'h1122_3344);
    mac_push(0, 32'h5566_7788);
    mac_push(0, 32'h99AA_BBCC);
    mac_push(1, 32'hA000_0001);
    mac_push(1, 32'hA000_0002);
    mac_push(2, 32'hB000_0001);

    for (int i = 0; i < NV; i++) begin
      logic [75:0] e;
      e = VEC[i];
      host_op(e[74], e[73], e[72], e[71:64], e[63:32], rv);
      if (e[75]) check($sformatf("R1-table vector %0d", i), rv, e[31:0]);
    end

    // R2 R7 R12: transmit data contents
    mac_take(v, d); check("R2 txd first", d, 32'hDEAD_BEEF);
    mac_take(v, d); check("R7 txd swapped", d, 32'h0403_0201);
    @(negedge clk); check("R12 no extra push", {31'b0, txd_m_valid}, 32'h0);

    // R8 sticky flag and clear
    check("R8 underrun set", {31'b0, underrun}, 32'h1);
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    check("R8 underrun cleared", {31'b0, underrun}, 32'h0);

    // R10 held read in normal mode pops consecutive entries
    mac_push(1, 32'hC1);
    mac_push(1, 32'hC2);
    @(negedge clk); host_rd = 1'b1; host_addr = 8'h40;
    @(negedge clk); check("R10 back-to-back first", host_rdata, 32'hC1);
    @(negedge clk); check("R10 back-to-back second", host_rdata, 32'hC2);
    host_rd = 1'b0;

    // R11 receive data back-pressure
    for (int k = 1; k <= 4; k++) mac_push(0, 32'(k));
    check("R11 rxd ready low when full", {31'b0, rxd_s_ready}, 32'h0);

    // R5 R6 direct burst
    @(negedge clk); direct_sel = 1'b1; host_rd = 1'b1; host_addr = 8'hF8;
    @(negedge clk); check("R6 burst dword 1", host_rdata, 32'h1); host_addr = 8'h34;
    @(negedge clk); check("R6 burst dword 2", host_rdata, 32'h2); host_addr = 8'h00;
    @(negedge clk); check("R6 burst dword 3", host_rdata, 32'h3); host_addr = 8'hC0;
    @(negedge clk); check("R6 upper bits ignored", host_rdata, 32'h3); host_rd = 1'b0;
    @(negedge clk);
    direct_sel = 1'b1;
    @(negedge clk); host_rd = 1'b1; host_addr = 8'h48;
    @(negedge clk); host_rd = 1'b0;
    check("R5 direct read at status addr", host_rdata, 32'h4);
    @(negedge clk); host_wr = 1'b1; host_addr = 8'h40; host_wdata = 32'hCAFE_0001;
    @(negedge clk); host_wdata = 32'hCAFE_0002;
    @(negedge clk); host_wr = 1'b0; direct_sel = 1'b0;
    mac_take(v, d); check("R5 direct write to txd", d, 32'hCAFE_0001);
    @(negedge clk); check("R6 held write pushes once", {31'b0, txd_m_valid}, 32'h0);

    // R9 overrun
    for (int k = 0; k < 5; k++) host_op(1'b0, 1'b1, 1'b0, 8'h24, 32'h10 + 32'(k), rv);
    check("R9 overrun set", {31'b0, overrun}, 32'h1);
    for (int k = 0; k < 4; k++) begin
      mac_take(v, d);
      check("R9 kept entry", d, 32'h10 + 32'(k));
    end
    @(negedge clk); check("R9 fifth dropped", {31'b0, txd_m_valid}, 32'h0);
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    check("R9 overrun cleared", {31'b0, overrun}, 32'h0);

    finish_run();
  end
endmodule